// File: doc/BRIEF.md
# Proportional Transmitter Phase Steering Loop

This block closes a proportional control loop around a transmitter's timing. At a steady cadence it is handed a signed timing error: how far the returned pulse sits from a reference epoch. From each error it forms a correction in proportion to that error and decides whether to ask a phase-stepping synthesizer to apply it. The synthesizer is the same one that applies manual phase offsets. It shifts phase by running at a slightly offset frequency for a while, and it signals completion with a done strobe.

The loop response is set by a time-constant input. The error is divided by a power of two chosen by this input, so a larger value gives a slower and gentler loop. Two gates stop the loop from reacting to noise. A minimum-steer magnitude suppresses small corrections, and a steer interval enforces a minimum number of error samples between two adjustments. An enable input stops the loop and clears its history.

Top module: `phase_steer_loop`

## Requirements
- R1: After reset, `step_req_o` is 0 and `step_o` is 0.
- R2: The correction is `err_i` divided by 2^`tc_shift_i` and rounded toward zero, so a negative error never rounds to a larger magnitude. When issued, it appears on `step_o` as a two's-complement value.
- R3: A correction is issued only if its magnitude is nonzero and is greater than or equal to `min_steer_i`, which is unsigned. Equal to the threshold issues; one below does not.
- R4: An adjustment may be issued only after at least `steer_interval_i` accepted samples have arrived since the previous adjustment or since enable. Samples rejected by the deadband still count toward this. The count restarts only when an adjustment is issued. A value of 0 allows every sample.
- R5: Once raised, `step_req_o` stays high with `step_o` unchanged until `step_done_i` is sampled high. It drops in the next cycle. Whenever `step_req_o` is low, `step_o` reads 0.
- R6: Error samples that arrive while `step_req_o` is high are ignored, including one in the same cycle as `step_done_i`. They do not advance the interval count.
- R7: While `enable_i` is low, the loop ignores samples, drops any pending request in the next cycle and clears its interval count.
- R8: An issued request is visible on `step_req_o` in the cycle that follows the accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Loop run enable |
| err_valid_i | input | 1 | Error sample strobe |
| err_i | input | ERR_W | Signed timing error |
| tc_shift_i | input | SHIFT_W | Time constant, expressed as a right-shift amount |
| min_steer_i | input | ERR_W | Unsigned minimum correction magnitude |
| steer_interval_i | input | INT_W | Minimum number of samples between adjustments |
| step_done_i | input | 1 | Synthesizer has finished the step |
| step_req_o | output | 1 | Phase step request |
| step_o | output | ERR_W | Signed phase step size |

## Verification
The bench uses negative errors that are not exact multiples of the divisor. A design that uses a plain arithmetic shift rounds these down, producing -26 instead of -25 and -1 instead of 0, and so issues steps it should not. It tests errors exactly at the deadband and one below it, the most negative error, and a full-width shift. It sends samples while a request is held and in the same cycle as done. A design that counted those samples, or acted on them, would issue early or change a step in flight. It also checks that deadband-rejected samples still count toward the interval, and that toggling enable clears the count, so that a counter reset on the wrong event shows up as an adjustment issued too early or too late.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int unsigned ERR_W_DEF   = 16;
  localparam int unsigned SHIFT_W_DEF = 4;
  localparam int unsigned INT_W_DEF   = 8;
endpackage

// File: rtl/steer_scale.sv
module steer_scale #(
  parameter int unsigned ERR_W   = 16,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic [ERR_W-1:0]   err_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [ERR_W:0]     mag_o,
  output logic [ERR_W-1:0]   corr_o
);
  logic              neg;
  logic signed [ERR_W:0] ext;
  logic [ERR_W:0]    mag_full;
  logic [ERR_W:0]    corr_wide;

  // magnitude path gives round-toward-zero for negative errors
  always_comb begin
    neg       = err_i[ERR_W-1];
    ext       = {err_i[ERR_W-1], err_i};
    mag_full  = neg ? unsigned'(-ext) : unsigned'(ext);
    mag_o     = mag_full >> shift_i;
    corr_wide = neg ? (~mag_o + 1'b1) : mag_o;
    corr_o    = corr_wide[ERR_W-1:0];
  end
endmodule

// File: rtl/steer_gate.sv
module steer_gate #(
  parameter int unsigned INT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             sample_i,
  input  logic             fire_i,
  input  logic [INT_W-1:0] interval_i,
  output logic             ready_o
);
  localparam logic [INT_W-1:0] CNT_MAX = {INT_W{1'b1}};

  logic [INT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!enable_i || fire_i)        cnt_q <= '0;
    else if (sample_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q >= interval_i);
endmodule

// File: rtl/steer_request.sv
module steer_request #(
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             fire_i,
  input  logic [ERR_W-1:0] step_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [ERR_W-1:0] step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      step_o <= '0;
    end else if (!enable_i) begin
      req_o  <= 1'b0;
      step_o <= '0;
    end else if (req_o) begin
      if (done_i) begin
        req_o  <= 1'b0;
        step_o <= '0;
      end
    end else if (fire_i) begin
      req_o  <= 1'b1;
      step_o <= step_i;
    end
  end
endmodule

// File: rtl/phase_steer_loop.sv
module phase_steer_loop
  import steer_pkg::*;
#(
  parameter int unsigned ERR_W   = ERR_W_DEF,
  parameter int unsigned SHIFT_W = SHIFT_W_DEF,
  parameter int unsigned INT_W   = INT_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               err_valid_i,
  input  logic [ERR_W-1:0]   err_i,
  input  logic [SHIFT_W-1:0] tc_shift_i,
  input  logic [ERR_W-1:0]   min_steer_i,
  input  logic [INT_W-1:0]   steer_interval_i,
  input  logic               step_done_i,
  output logic               step_req_o,
  output logic [ERR_W-1:0]   step_o
);
  logic [ERR_W:0]   corr_mag;
  logic [ERR_W-1:0] corr;
  logic             accept, pass, ready, fire;

  steer_scale #(.ERR_W(ERR_W), .SHIFT_W(SHIFT_W)) u_scale (
    .err_i  (err_i),
    .shift_i(tc_shift_i),
    .mag_o  (corr_mag),
    .corr_o (corr)
  );

  // busy loop ignores samples
  assign accept = enable_i && err_valid_i && !step_req_o;
  assign pass   = (corr_mag != '0) && (corr_mag >= {1'b0, min_steer_i});
  assign fire   = accept && pass && ready;

  steer_gate #(.INT_W(INT_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .sample_i  (accept),
    .fire_i    (fire),
    .interval_i(steer_interval_i),
    .ready_o   (ready)
  );

  steer_request #(.ERR_W(ERR_W)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .fire_i  (fire),
    .step_i  (corr),
    .done_i  (step_done_i),
    .req_o   (step_req_o),
    .step_o  (step_o)
  );
endmodule

// File: rtl/phase_steer_loop_chk.sv
module phase_steer_loop_chk #(
  parameter int unsigned ERR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             err_valid_i,
  input logic [ERR_W-1:0] min_steer_i,
  input logic             step_done_i,
  input logic             step_req_o,
  input logic [ERR_W-1:0] step_o
);
  logic [ERR_W:0] step_mag;
  assign step_mag = step_o[ERR_W-1] ? unsigned'(-$signed({step_o[ERR_W-1], step_o}))
                                    : {1'b0, step_o};

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_req_o && !step_done_i && enable_i) |=> (step_req_o && $stable(step_o)));

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_req_o && step_done_i) |=> !step_req_o);

  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_req_o |-> (step_o == '0));

  assert_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !step_req_o);

  assert_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_req_o) |-> $past(err_valid_i && enable_i));

  assert_deadband_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_req_o) |-> (step_mag != '0 && step_mag >= {1'b0, $past(min_steer_i)}));
endmodule

bind phase_steer_loop phase_steer_loop_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .err_valid_i(err_valid_i),
  .min_steer_i(min_steer_i),
  .step_done_i(step_done_i),
  .step_req_o (step_req_o),
  .step_o     (step_o)
);

// File: tb/phase_steer_loop_test.sv
module phase_steer_loop_test;
  localparam int ERR_W = 16, SHIFT_W = 4, INT_W = 8, NV = 11;

  logic clk_i = 0, rst_ni = 0, enable_i = 0, err_valid_i = 0, step_done_i = 0;
  logic [ERR_W-1:0] err_i = '0, min_steer_i = '0;
  logic [SHIFT_W-1:0] tc_shift_i = '0;
  logic [INT_W-1:0] steer_interval_i = '0;
  logic step_req_o;
  logic [ERR_W-1:0] step_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  phase_steer_loop uut (.*);

  localparam int V_ERR  [NV] = '{100, -100, -101, 7, -7, 40, 39, -32768, 32767, -32768, -300};
  localparam int V_TC   [NV] = '{2, 2, 2, 3, 3, 0, 0, 0, 15, 15, 1};
  localparam int V_MIN  [NV] = '{1, 1, 1, 1, 0, 40, 40, 1, 0, 1, 200};
  localparam int V_ISS  [NV] = '{1, 1, 1, 0, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_STEP [NV] = '{25, -25, -25, 0, 0, 40, 0, -32768, 0, -1, 0};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sstep();
    return int'($signed(step_o));
  endfunction

  task automatic sample(input int e);
    @(negedge clk_i);
    err_valid_i = 1; err_i = ERR_W'(e);
    @(negedge clk_i);
    err_valid_i = 0;
  endtask

  task automatic complete();
    step_done_i = 1;
    @(negedge clk_i);
    step_done_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 req", int'(step_req_o), 0);
    chk("R1 step", sstep(), 0);
    rst_ni = 1; enable_i = 1;
    @(negedge clk_i);

    // table: interval 0, R2/R3/R8
    for (int i = 0; i < NV; i++) begin
      tc_shift_i = SHIFT_W'(V_TC[i]); min_steer_i = ERR_W'(V_MIN[i]); steer_interval_i = '0;
      sample(V_ERR[i]);
      chk($sformatf("R8/R3 issue vec%0d", i), int'(step_req_o), V_ISS[i]);
      chk($sformatf("R2 step vec%0d", i), sstep(), V_STEP[i]);
      if (step_req_o) begin
        complete();
        chk($sformatf("R5 drop vec%0d", i), int'(step_req_o), 0);
      end
    end

    // R5 hold and R6 busy ignore
    tc_shift_i = '0; min_steer_i = 1;
    sample(10);
    chk("R8 busy issue", int'(step_req_o), 1);
    repeat (3) begin
      @(negedge clk_i);
      chk("R5 hold req", int'(step_req_o), 1);
      chk("R5 hold step", sstep(), 10);
    end
    sample(500);
    chk("R6 busy sample ignored", sstep(), 10);
    sample(-600);
    chk("R6 busy sample2 ignored", sstep(), 10);
    step_done_i = 1; err_valid_i = 1; err_i = ERR_W'(77);
    @(negedge clk_i);
    step_done_i = 0; err_valid_i = 0;
    chk("R6 done-cycle sample req", int'(step_req_o), 0);
    chk("R5 idle step zero", sstep(), 0);

    // R4 interval; busy samples must not have counted (R6)
    steer_interval_i = 2; min_steer_i = 5;
    sample(50);
    chk("R4/R6 first gated", int'(step_req_o), 0);
    sample(1);
    chk("R3 small rejected", int'(step_req_o), 0);
    sample(50);
    chk("R4 deadband sample counted", int'(step_req_o), 1);
    chk("R4 step", sstep(), 50);
    complete();
    sample(50);
    chk("R4 restart after issue", int'(step_req_o), 0);

    // R7 disable clears counter, ignores samples
    steer_interval_i = 1;
    @(negedge clk_i); enable_i = 0;
    sample(50);
    chk("R7 disabled ignore", int'(step_req_o), 0);
    enable_i = 1;
    sample(50);
    chk("R7 counter cleared", int'(step_req_o), 0);
    sample(-50);
    chk("R7 issue after count", int'(step_req_o), 1);
    chk("R7 step", sstep(), -50);
    enable_i = 0;
    @(negedge clk_i);
    chk("R7 drop on disable", int'(step_req_o), 0);
    chk("R7 step zero", sstep(), 0);
    enable_i = 1;

    // R1 async reset mid-request
    steer_interval_i = 0;
    sample(30);
    chk("R8 pre-reset issue", int'(step_req_o), 1);
    rst_ni = 0; #1;
    chk("R1 reset req", int'(step_req_o), 0);
    chk("R1 reset step", sstep(), 0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule